// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

The block is a watchdog that runs entirely on its own free-running clock. That clock stands in for an on-chip RC oscillator. It keeps counting while the main system oscillator is stopped for sleep. When the watchdog is enabled and software has not cleared it in time, it raises a one-cycle reset request. The rest of the chip routes that request to the system reset. This happens whether the device is running or asleep.

Software can turn the watchdog on or off in any cycle. While it is off, both internal counters sit at zero and no request is raised. The timeout is a parameterized number of base ticks, `TIMEOUT`. An optional 8-bit prescaler stretches the timeout. A 3-bit select picks one of eight taps, which divides the watchdog clock by 2, 4, 8 and so on up to 256 before it reaches the base counter.

A clear (kick) input restarts both counters. This is the path a watchdog-clear instruction drives.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rst_req` is 0 and both counters are zero.
- R2: With `wd_en`=1 and `pre_on`=0, `rst_req` goes high exactly `TIMEOUT` clock cycles after the last restart edge (a kick, an enable, a reset release, or a previous timeout).
- R3: With `pre_on`=1, each base tick needs 2^(`pre_sel`+1) clock cycles (`pre_sel`=0 gives 2, `pre_sel`=7 gives 256). `rst_req` therefore rises `TIMEOUT`*2^(`pre_sel`+1) cycles after the last restart.
- R4: `rst_req` is high for exactly one cycle. On the edge that raises it, both counters restart, so the next request comes a full period later.
- R5: `kick`=1 at a clock edge clears the prescaler and the base counter. If that edge would have been the timeout edge, the kick wins and no request is raised.
- R6: While `wd_en`=0, no request is raised and both counters are held at zero. After `wd_en` returns to 1, a full period elapses before a request.
- R7: `sleep` has no effect on counting or on `rst_req`. The watchdog times out in sleep exactly as it does when awake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_wdt | input | 1 | Free-running watchdog clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_en | input | 1 | Watchdog enable, may change in any cycle |
| pre_on | input | 1 | 1: prescaler feeds the base counter; 0: base counts every cycle |
| pre_sel | input | 3 | Prescaler tap, divide ratio 2^(pre_sel+1) |
| kick | input | 1 | Clear both counters (watchdog-clear) |
| sleep | input | 1 | Device sleep indication; does not affect counting |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
A kick and a timeout can land on the same clock edge. The clear must win, leaving no request and fresh counters. The bench provokes this in two ways. In a directed case it kicks on exactly the cycle `TIMEOUT` after a restart. The random phase also produces many chance coincidences. A bench model counts cycles since the last restart. It judges each cycle by expecting no pulse when the kick arrives and a full period afterwards. The same model also covers a disable that lands on the timeout edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int PRE_BITS = 8;
    localparam int SEL_BITS = $clog2(PRE_BITS);

    // control shared by both counters
    typedef struct packed {
        logic hold;   // watchdog disabled: keep counters at zero
        logic clear;  // kick or timeout: restart counters
    } wdog_ctl_t;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter  int PRE_W = PRE_BITS,
    localparam int SEL_W = $clog2(PRE_W)
) (
    input  logic             clk_wdt,
    input  logic             rst_n,
    input  wdog_ctl_t        ctl,
    input  logic             pre_on,
    input  logic [SEL_W-1:0] pre_sel,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] tap;

    // tap i fires when the low i+1 bits are all ones: divide by 2^(i+1)
    for (genvar i = 0; i < PRE_W; i++) begin : g_tap
        assign tap[i] = &st_q.cnt[i:0];
    end

    assign tick = pre_on ? tap[pre_sel] : 1'b1;

    always_comb begin
        st_d = st_q;
        if (ctl.hold || ctl.clear || !pre_on) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_wdt or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRE_IDLE_ZERO: assert property (@(posedge clk_wdt) disable iff (!rst_n)
        (ctl.hold || !pre_on) |=> (st_q.cnt == '0)); // R6

    AST_PRE_ADVANCES: assert property (@(posedge clk_wdt) disable iff (!rst_n)
        (!ctl.hold && !ctl.clear && pre_on) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R3

endmodule

// File: rtl/wdog_base_cnt.sv
module wdog_base_cnt
    import wdog_pkg::*;
#(
    parameter  int TIMEOUT = 16,
    localparam int CNT_W   = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
    input  logic             clk_wdt,
    input  logic             rst_n,
    input  wdog_ctl_t        ctl,
    input  logic             tick,
    output logic             expire,
    output logic [CNT_W-1:0] base_cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } base_state_t;

    base_state_t st_d, st_q;

    assign expire   = tick && (st_q.cnt == LAST);
    assign base_cnt = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (ctl.hold || ctl.clear) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_wdt or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_BASE_IN_RANGE: assert property (@(posedge clk_wdt) disable iff (!rst_n)
        st_q.cnt <= LAST); // R2

    AST_BASE_WAITS_TICK: assert property (@(posedge clk_wdt) disable iff (!rst_n)
        (!tick && !ctl.hold && !ctl.clear) |=> $stable(st_q.cnt)); // R3

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter  int TIMEOUT = 16,
    parameter  int PRE_W   = PRE_BITS,
    localparam int SEL_W   = $clog2(PRE_W),
    localparam int CNT_W   = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
    input  logic             clk_wdt,
    input  logic             rst_n,
    input  logic             wd_en,
    input  logic             pre_on,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic             kick,
    input  logic             sleep,
    output logic             rst_req
);

    typedef struct packed {
        logic req;
    } top_state_t;

    top_state_t       st_d, st_q;
    wdog_ctl_t        ctl;
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] base_cnt;
    logic             sleep_unused;

    // the watchdog clock never stops, so sleep changes nothing here
    assign sleep_unused = sleep;

    always_comb begin
        ctl.hold  = !wd_en;
        ctl.clear = kick || expire;
        st_d      = st_q;
        st_d.req  = wd_en && !kick && expire;
    end

    always_ff @(posedge clk_wdt or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req = st_q.req;

    wdog_prescaler #(
        .PRE_W   (PRE_W)
    ) i_pre (
        .clk_wdt (clk_wdt),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .pre_on  (pre_on),
        .pre_sel (pre_sel),
        .tick    (tick)
    );

    wdog_base_cnt #(
        .TIMEOUT  (TIMEOUT)
    ) i_base (
        .clk_wdt  (clk_wdt),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .tick     (tick),
        .expire   (expire),
        .base_cnt (base_cnt)
    );

    initial begin
        AST_TIMEOUT_MIN: assert (TIMEOUT >= 2); // R4
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk_wdt) disable iff (!rst_n)
        rst_req |=> !rst_req); // R4

    AST_REQ_RESTARTS: assert property (@(posedge clk_wdt) disable iff (!rst_n)
        rst_req |-> (base_cnt == '0)); // R4

    AST_KICK_WINS: assert property (@(posedge clk_wdt) disable iff (!rst_n)
        kick |=> (!rst_req && base_cnt == '0)); // R5

    AST_DISABLED_QUIET: assert property (@(posedge clk_wdt) disable iff (!rst_n)
        !wd_en |=> (!rst_req && base_cnt == '0)); // R6

endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

    localparam int TO = 5;

    logic       clk_wdt = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wd_en   = 1'b0;
    logic       pre_on  = 1'b0;
    logic [2:0] pre_sel = 3'd0;
    logic       kick    = 1'b0;
    logic       sleep   = 1'b0;
    logic       rst_req;

    int errors = 0;
    int checks = 0;
    int mc     = 0;
    bit exp_req = 1'b0;
    bit done    = 1'b0;

    always #10 clk_wdt = ~clk_wdt;  // 50 MHz

    wdog_timer #(.TIMEOUT(TO)) i_wdog_timer (
        .clk_wdt (clk_wdt),
        .rst_n   (rst_n),
        .wd_en   (wd_en),
        .pre_on  (pre_on),
        .pre_sel (pre_sel),
        .kick    (kick),
        .sleep   (sleep),
        .rst_req (rst_req)
    );

    function automatic int period(bit on, logic [2:0] sel);
        return on ? TO * (2 << sel) : TO;
    endfunction

    task automatic check(string tag);
        checks++;
        if (rst_req !== exp_req) begin
            errors++;
            $display("FAIL %s: rst_req=%b expected=%b at %0t", tag, rst_req, exp_req, $time);
        end
    endtask

    // one clock: model update at the edge, compare and drive away from it
    task automatic cyc(string tag);
        @(posedge clk_wdt);
        if (!rst_n || !wd_en || kick) begin
            mc = 0; exp_req = 1'b0;
        end else begin
            mc++;
            if (mc == period(pre_on, pre_sel)) begin
                exp_req = 1'b1; mc = 0;
            end else begin
                exp_req = 1'b0;
            end
        end
        #2;
        check(tag);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic do_kick(string tag);
        kick = 1'b1; cyc(tag); kick = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, checks=%0d expected completion", checks);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1d0c);
        // R1: reset state
        #3;
        check("R1");
        run(3, "R1");
        rst_n = 1'b1; wd_en = 1'b1;
        cyc("R1");
        // R2 / R4: no prescaler, pulses every TO cycles
        do_kick("R2");
        run(3 * TO + 2, "R4");
        // R3: prescaler taps
        pre_on = 1'b1; pre_sel = 3'd0; do_kick("R3");
        run(2 * period(1'b1, 3'd0) + 3, "R3");
        pre_sel = 3'd2; do_kick("R3");
        run(period(1'b1, 3'd2) + 3, "R3");
        pre_sel = 3'd7; do_kick("R3");
        run(period(1'b1, 3'd7) + 3, "R3");
        // R5: kick lands exactly on the timeout edge
        pre_on = 1'b0; do_kick("R5");
        run(TO - 1, "R5");
        do_kick("R5");
        run(TO + 2, "R5");
        pre_on = 1'b1; pre_sel = 3'd1; do_kick("R5");
        run(period(1'b1, 3'd1) - 1, "R5");
        do_kick("R5");
        run(period(1'b1, 3'd1) + 2, "R5");
        // R6: disable on the timeout edge, idle, re-enable
        pre_on = 1'b0; do_kick("R6");
        run(TO - 1, "R6");
        wd_en = 1'b0;
        run(20, "R6");
        wd_en = 1'b1;
        run(TO + 2, "R6");
        // R7: sleep does not stop counting
        sleep = 1'b1; do_kick("R7");
        run(2 * TO + 1, "R7");
        pre_on = 1'b1; pre_sel = 3'd3; do_kick("R7");
        run(period(1'b1, 3'd3) + 2, "R7");
        sleep = 1'b0;
        // random mix (R5, R6, R7)
        for (int i = 0; i < 4000; i++) begin
            sleep = 1'($urandom_range(0, 1));
            kick  = ($urandom_range(0, 59) == 0);
            if ($urandom_range(0, 149) == 0) wd_en = ~wd_en;
            if (kick || !wd_en) begin
                pre_on  = 1'($urandom_range(0, 1));
                pre_sel = 3'($urandom_range(0, 2));
            end
            cyc("R5");
        end
        kick = 1'b0; wd_en = 1'b1;
        run(2, "R6");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule